// File: doc/BRIEF.md
# Priority Interrupt Code Selector

This block finds the interrupt line that should be serviced next. It takes a pending vector, a mask vector and a routing vector for one to three banks of 32 lines, plus a priority field for each line. It also takes a requested service class, normal or fast. A line is a candidate when it is pending, not masked, and routed to the requested class. Among the candidates, the smallest priority value wins. If several candidates share that value, the line with the larger global number wins.

A search begins on a one-cycle start strobe. The block then walks the lines one per clock, from line 0 upward. When the walk ends it loads the winning line number into its code output and raises a done pulse for one clock. The line number is the bank index times 32 plus the bit position inside the bank. If no line qualifies, the code is zero. An interrupt controller uses the block behind its register interface. The controller drives start whenever it needs a fresh vector code, and it keeps the inputs steady until done.

Top module: `intc_prio_sel`

## Requirements
- R1: A line takes part only when its pending bit is 1, its mask bit is 0, and its routing bit equals `class_fast_i`. Routing bit 1 means the fast class and routing bit 0 means the normal class. Masked lines, non-pending lines and lines of the other class never win, whatever their priority.
- R2: Among the candidates, the line with the numerically smallest priority field wins. Value 0 is the most urgent.
- R3: When several candidates share the smallest priority, the one with the largest global line number wins. This holds inside a bank and across banks.
- R4: The reported code for bit `i` of bank `b` is `32*b + i`. That line's pending, mask and routing bits sit at vector position `32*b + i`. Its priority occupies `prio_i[(32*b+i)*PRIO_W +: PRIO_W]`.
- R5: When no line is a candidate, the reported code is 0.
- R6: The priority field is `PRIO_W` bits wide: 5 for a single-bank build, 6 for a three-bank build. All of its bits take part in the comparison. With the default width of 6, value 31 beats value 32, and value 62 beats value 63.
- R7: Let `start_i` be sampled high at rising edge k while the block is idle. Then `done_o` is high for exactly one clock, after edge k + `NUM_BANKS*32`.
- R8: `code_o` changes only in the clock where `done_o` rises. A `start_i` pulse that arrives while a search is running is ignored. Changing the inputs after done does not alter `code_o`.
- R9: While `rst_n` is low at a rising edge (synchronous, active low), `code_o` is cleared to 0, `done_o` to 0, and any running search is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launch one search when idle |
| class_fast_i | input | 1 | Requested class: 1 selects fast-routed lines, 0 selects normal lines |
| pending_i | input | NUM_BANKS*32 | Pending bit for each line |
| mask_i | input | NUM_BANKS*32 | Mask bit for each line; 1 blocks the line |
| route_i | input | NUM_BANKS*32 | Routing bit for each line; 1 sends the line to the fast class |
| prio_i | input | NUM_BANKS*32*PRIO_W | Packed priority fields, line 0 in the low bits |
| code_o | output | $clog2(NUM_BANKS*32) | Winning line number, held between searches |
| done_o | output | 1 | One-clock pulse when `code_o` holds a fresh result |

## Verification
The assertions assume that pending, mask, routing, priority and class stay constant from the start strobe until the clock in which done is high. Under that assumption the checker can compare the reported code against the candidate set seen at the done clock. The bench meets this by changing inputs only while the block is idle. It alters the inputs only after it has sampled the done pulse and the following low clock. The one mid-search stimulus is a second start pulse, and it leaves the data inputs untouched.

// File: rtl/intc_sel_pkg.sv
// Shared definitions for the priority interrupt code selector.
// Assumes nothing beyond a two-state search controller.
package intc_sel_pkg;
    typedef enum logic {
        SEL_IDLE = 1'b0,
        SEL_SCAN = 1'b1
    } sel_state_e;
endpackage

// File: rtl/sel_cand_filter.sv
// Candidate filter: marks each line that is pending, unmasked and routed to
// the requested class. Purely combinational; assumes vectors are line-indexed.
module sel_cand_filter #(
    parameter int NL = 96
) (
    input  logic [NL-1:0] pending_i,
    input  logic [NL-1:0] mask_i,
    input  logic [NL-1:0] route_i,
    input  logic          class_fast_i,
    output logic [NL-1:0] cand_o
);
    // One qualifying gate per line
    for (genvar g = 0; g < NL; g++) begin : g_line
        assign cand_o[g] = pending_i[g] & ~mask_i[g] & (route_i[g] == class_fast_i);
    end
endmodule

// File: rtl/sel_scan_ctrl.sv
// Search controller: on a start strobe while idle, steps a line index from 0
// up to NL-1, one line per clock, then returns to idle. A start during a scan
// is ignored. Assumes synchronous active-low reset.
module sel_scan_ctrl
    import intc_sel_pkg::*;
#(
    parameter int NL    = 96,
    parameter int IDX_W = $clog2(NL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             launch_o,
    output logic             scanning_o,
    output logic             last_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NL - 1);

    sel_state_e       state_q;
    logic [IDX_W-1:0] idx_q;

    // Decode controller status from the state and index
    always_comb begin
        launch_o   = (state_q == SEL_IDLE) && start_i;
        scanning_o = (state_q == SEL_SCAN);
        last_o     = scanning_o && (idx_q == LAST_IDX);
        idx_o      = idx_q;
    end

    // Advance the state and the line index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEL_IDLE;
            idx_q   <= '0;
        end else if (launch_o) begin
            state_q <= SEL_SCAN;
            idx_q   <= '0;
        end else if (scanning_o) begin
            if (idx_q == LAST_IDX) begin
                state_q <= SEL_IDLE;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sel_best_track.sv
// Running-best tracker: holds the best line seen so far in a scan. The update
// uses a less-or-equal compare, so an ascending scan hands ties to the
// highest-numbered line. The starting priority is all ones, so any candidate
// wins against it. Exposes the next value so the final line can be folded in
// on the same edge.
module sel_best_track #(
    parameter int PRIO_W = 6,
    parameter int IDX_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  logic              step_i,
    input  logic              cand_i,
    input  logic [PRIO_W-1:0] prio_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [IDX_W-1:0]  nxt_code_o
);
    logic [IDX_W-1:0]  run_code_q;
    logic [PRIO_W-1:0] run_prio_q;
    logic [PRIO_W-1:0] nxt_prio;
    logic              take;

    // Decide whether the current line replaces the running best
    always_comb begin
        take       = step_i && cand_i && (prio_i <= run_prio_q);
        nxt_code_o = take ? idx_i  : run_code_q;
        nxt_prio   = take ? prio_i : run_prio_q;
    end

    // Reset the running best at launch, update it while scanning
    always_ff @(posedge clk) begin
        if (!rst_n || launch_i) begin
            run_code_q <= '0;
            run_prio_q <= '1;
        end else if (step_i) begin
            run_code_q <= nxt_code_o;
            run_prio_q <= nxt_prio;
        end
    end
endmodule

// File: rtl/intc_prio_sel.sv
// Priority interrupt code selector top. Filters lines by pending, mask and
// class, scans them in ascending order, and publishes the winning line number
// with a one-clock done pulse. Assumes all data inputs and the class stay
// stable from start until done.
module intc_prio_sel #(
    parameter int  NUM_BANKS = 3,
    parameter int  PRIO_W    = 6,
    localparam int NL        = NUM_BANKS * 32,
    localparam int IDX_W     = $clog2(NL)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 class_fast_i,
    input  logic [NL-1:0]        pending_i,
    input  logic [NL-1:0]        mask_i,
    input  logic [NL-1:0]        route_i,
    input  logic [NL*PRIO_W-1:0] prio_i,
    output logic [IDX_W-1:0]     code_o,
    output logic                 done_o
);
    logic [NL-1:0]     cand;
    logic              launch;
    logic              scanning;
    logic              last;
    logic [IDX_W-1:0]  idx;
    logic              cur_cand;
    logic [PRIO_W-1:0] cur_prio;
    logic [IDX_W-1:0]  nxt_code;

    sel_cand_filter #(.NL(NL)) u_filter (
        .pending_i    (pending_i),
        .mask_i       (mask_i),
        .route_i      (route_i),
        .class_fast_i (class_fast_i),
        .cand_o       (cand)
    );

    sel_scan_ctrl #(.NL(NL), .IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .launch_o   (launch),
        .scanning_o (scanning),
        .last_o     (last),
        .idx_o      (idx)
    );

    // Pick out the candidate bit and the priority field of the scanned line
    always_comb begin
        cur_cand = cand[idx];
        cur_prio = prio_i[int'(idx) * PRIO_W +: PRIO_W];
    end

    sel_best_track #(.PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_best (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch_i   (launch),
        .step_i     (scanning),
        .cand_i     (cur_cand),
        .prio_i     (cur_prio),
        .idx_i      (idx),
        .nxt_code_o (nxt_code)
    );

    // Publish the result and the done pulse when the last line is folded in
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= last;
            if (last) begin
                code_o <= nxt_code;
            end
        end
    end
endmodule

// File: rtl/sel_chk.sv
// Property checker for the priority interrupt code selector. Tracks search
// timing with its own counter. Assumes the inputs are steady from start
// through the done clock.
module sel_chk #(
    parameter int NL    = 96,
    parameter int IDX_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             class_fast_i,
    input logic [NL-1:0]    pending_i,
    input logic [NL-1:0]    mask_i,
    input logic [NL-1:0]    route_i,
    input logic [IDX_W-1:0] code_o,
    input logic             done_o
);
    logic             busy_q;
    logic [IDX_W-1:0] cnt_q;
    logic             fin;
    logic [NL-1:0]    qual;

    // Observe when the last scan cycle should occur and which lines qualify
    always_comb begin
        fin  = busy_q && (cnt_q == IDX_W'(NL - 1));
        qual = pending_i & ~mask_i & (class_fast_i ? route_i : ~route_i);
    end

    // Independent search-length counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!busy_q && start_i) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (fin) busy_q <= 1'b0;
            else     cnt_q  <= cnt_q + 1'b1;
        end
    end

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    done_follows_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> done_o);

    // R7
    done_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(fin));

    // R5
    empty_code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (qual == '0)) |-> (code_o == '0));

    // R1
    winner_qualifies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (qual != '0)) |-> qual[code_o]);

    // R8
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(code_o));
endmodule

bind intc_prio_sel sel_chk #(.NL(NL), .IDX_W(IDX_W)) u_sel_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .class_fast_i (class_fast_i),
    .pending_i    (pending_i),
    .mask_i       (mask_i),
    .route_i      (route_i),
    .code_o       (code_o),
    .done_o       (done_o)
);

// File: tb/tb_intc_prio_sel.sv
module tb_intc_prio_sel;
    localparam int NB    = 3;
    localparam int PW    = 6;
    localparam int NL    = NB * 32;
    localparam int IDX_W = $clog2(NL);

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start_i = 1'b0;
    logic                class_fast_i = 1'b0;
    logic [NL-1:0]       pending_i = '0;
    logic [NL-1:0]       mask_i = '1;
    logic [NL-1:0]       route_i = '0;
    logic [NL*PW-1:0]    prio_i = '0;
    logic [IDX_W-1:0]    code_o;
    logic                done_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    intc_prio_sel #(.NUM_BANKS(NB), .PRIO_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .class_fast_i(class_fast_i),
        .pending_i(pending_i), .mask_i(mask_i), .route_i(route_i),
        .prio_i(prio_i), .code_o(code_o), .done_o(done_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_lines();
        pending_i = '0; mask_i = '0; route_i = '0; prio_i = '0; class_fast_i = 1'b0;
    endtask

    task automatic set_line(input int n, input int pr, input logic rt);
        pending_i[n] = 1'b1;
        route_i[n]   = rt;
        prio_i[n*PW +: PW] = PW'(pr);
    endtask

    // Independent model: descending walk with strict less-than
    function automatic int model();
        int best = 0;
        int bp = 1 << PW;
        for (int i = NL - 1; i >= 0; i--) begin
            if (pending_i[i] && !mask_i[i] && (route_i[i] == class_fast_i) &&
                int'(prio_i[i*PW +: PW]) < bp) begin
                best = i;
                bp = int'(prio_i[i*PW +: PW]);
            end
        end
        return best;
    endfunction

    // Launch a search, time the done pulse (R7), return the code
    task automatic run_search(output int code, input int extra_at);
        int n = 0;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        while (n < NL + 20) begin
            @(negedge clk);
            n++;
            start_i = (n == extra_at);
            if (done_o) break;
        end
        start_i = 1'b0;
        chk("R7 done latency", n, NL);
        code = int'(code_o);
        @(negedge clk);
        chk("R7 done single cycle", int'(done_o), 0);
    endtask

    task automatic t_reset();
        int c;
        chk("R9 reset code", int'(code_o), 0);
        chk("R9 reset done", int'(done_o), 0);
        clear_lines();
        set_line(77, 3, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        run_search(c, -1);
        chk("R4 pre-reset code", c, 77);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        chk("R9 code cleared by reset", int'(code_o), 0);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic t_filter();
        int c;
        clear_lines();
        set_line(70, 0, 1'b0); mask_i[70] = 1'b1;
        set_line(40, 0, 1'b1);
        set_line(10, 5, 1'b0);
        prio_i[90*PW +: PW] = '0;
        run_search(c, -1);
        chk("R1 normal class skips masked and fast", c, model());
        chk("R1 normal class winner", c, 10);
        class_fast_i = 1'b1;
        run_search(c, -1);
        chk("R1 fast class winner", c, 40);
        class_fast_i = 1'b0; mask_i[70] = 1'b0;
        run_search(c, -1);
        chk("R1 unmasked line wins", c, 70);
    endtask

    task automatic t_priority();
        int c;
        clear_lines();
        set_line(3, 1, 1'b0); set_line(50, 9, 1'b0); set_line(95, 9, 1'b0);
        run_search(c, -1);
        chk("R2 smallest value wins", c, 3);
        prio_i[50*PW +: PW] = '0;
        run_search(c, -1);
        chk("R2 zero most urgent", c, 50);
    endtask

    task automatic t_tie();
        int c;
        clear_lines();
        set_line(5, 7, 1'b1); set_line(33, 7, 1'b1); set_line(64, 7, 1'b1);
        class_fast_i = 1'b1;
        run_search(c, -1);
        chk("R3 tie across banks", c, 64);
        clear_lines();
        set_line(12, 0, 1'b0); set_line(13, 0, 1'b0);
        run_search(c, -1);
        chk("R3 tie inside bank", c, 13);
    endtask

    task automatic t_bank_code();
        int c;
        clear_lines();
        set_line(65, 4, 1'b0);
        run_search(c, -1);
        chk("R4 bank 2 bit 1", c, 65);
        clear_lines();
        set_line(63, 4, 1'b0);
        run_search(c, -1);
        chk("R4 bank 1 bit 31", c, 63);
    endtask

    task automatic t_empty();
        int c;
        clear_lines();
        set_line(20, 1, 1'b0); set_line(60, 1, 1'b0);
        mask_i = '1;
        run_search(c, -1);
        chk("R5 all masked gives zero", c, 0);
        mask_i = '0; class_fast_i = 1'b1;
        run_search(c, -1);
        chk("R5 class mismatch gives zero", c, 0);
    endtask

    task automatic t_wide();
        int c;
        clear_lines();
        set_line(80, 32, 1'b0); set_line(10, 31, 1'b0);
        run_search(c, -1);
        chk("R6 value 31 beats 32", c, 10);
        prio_i[80*PW +: PW] = PW'(62); prio_i[10*PW +: PW] = PW'(63);
        run_search(c, -1);
        chk("R6 value 62 beats 63", c, 80);
    endtask

    task automatic t_busy_hold();
        int c;
        clear_lines();
        set_line(44, 2, 1'b0); set_line(8, 6, 1'b0);
        run_search(c, 10);
        chk("R8 mid-search start ignored", c, 44);
        pending_i = '1; prio_i = '0;
        repeat (5) @(negedge clk);
        chk("R8 code held after input change", int'(code_o), 44);
        chk("R8 no spurious done", int'(done_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_filter();
        t_priority();
        t_tie();
        t_bank_code();
        t_empty();
        t_wide();
        t_busy_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule